// File: doc/BRIEF.md
# Host Command Packet Decoder

This block sits behind the serial receive shifter of a keyboard and power controller. It takes the host's command bytes one at a time and frames them into packets. Every packet opens with an escape byte and carries a command code. It closes with a folded XOR check byte, and its length is fixed by the command code. The block enforces a minimum and a maximum spacing between the bytes of a packet. When a packet is good, it raises one decoded strobe or updates its own general-purpose-pin registers. When a packet is bad (wrong check byte, unknown code, illegal value, or bytes too close together or too far apart), it raises a resend request. The response builder uses that request to send the resend packet to the host.

The byte input is a valid/ready stream. `in_ready` is tied high: the decoder takes one byte on every cycle in which `in_valid` is high and never applies back-pressure. The byte source must hold `in_valid` for exactly the cycles it means to deliver. All decoded outputs are one-cycle pulses. Each pulse appears on the second rising edge after the edge that took the packet's last byte. The register outputs change on that same edge.

Top module: `host_cmd_decoder`

## Requirements
- R1: A packet starts only with byte 1Bh. While no packet is open, any other byte is dropped with no strobe, no resend and no change to any register.
- R2: The check byte is the XOR of every earlier byte of the packet. When bit 7 of that XOR is 1, the value is further XORed with C0h (1Bh, A0h gives 7Bh). On a mismatch, `resend_p` pulses once and no command strobe fires.
- R3: Byte 2 is the command code. Codes A0h, A1h, A2h and F2h form 3-byte packets and pulse `init_p`, `init_done_p`, `heartbeat_p` and `ident_p` respectively. A code outside {A0h, A1h, A2h, F2h, A7h, A8h, A9h} pulses `resend_p` and closes the packet.
- R4: A7h (5 bytes: code, pin number, value, check) handles the pin mode. Value 0–3 is written to `gio_mode` (0 input, 1 output, 2 switch, 3 LED), and value 1 also forces `gio_out` low. Value 4 pulses `mode_query_p` and leaves the mode as it is. Values above 4 pulse `resend_p` and change nothing.
- R5: A8h (5 bytes) handles the pin data. Value 0 or 1 is written to `gio_out` only while `gio_mode` is 1, and is ignored in any other mode. Value 2 pulses `data_query_p`. Values above 2 pulse `resend_p`.
- R6: A9h is an 18-byte packet with 15 mask bytes between the code and the check byte. On a good packet, `wake_load_p` pulses and the first mask byte lands in `wake_mask[7:0]`, with each following byte 8 bits higher, up to the switch byte in `wake_mask[119:112]`.
- R7: After reset, and after a good A0h packet, `gio_mode` is 0 and `gio_out` is 0.
- R8: Inside an open packet, a byte that comes fewer than MIN_GAP cycles after the previous byte discards the packet and pulses `resend_p`.
- R9: An open packet with no new byte for more than MAX_GAP cycles is discarded with exactly one `resend_p` pulse, including when a late byte comes on the timeout cycle. A byte exactly MAX_GAP or MIN_GAP cycles after the previous one is accepted.
- R10: `in_ready` is always 1. Strobes and `resend_p` are single-cycle, at most one at a time, two edges after the last byte's accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host byte present |
| in_ready | output | 1 | Always 1 |
| in_data | input | 8 | Host byte |
| init_p | output | 1 | Initialize command strobe |
| init_done_p | output | 1 | Initialization-complete strobe |
| heartbeat_p | output | 1 | Heartbeat request strobe |
| ident_p | output | 1 | Identification request strobe |
| mode_query_p | output | 1 | Pin mode report requested |
| data_query_p | output | 1 | Pin data report requested |
| wake_load_p | output | 1 | Wake mask loaded |
| wake_mask | output | 120 | Fifteen wake-mask bytes, first byte lowest |
| resend_p | output | 1 | Ask the transmit side for a resend packet |
| gio_mode | output | 3 | Pin mode register |
| gio_out | output | 1 | Pin output data register |

## Verification
Two events can land on the same cycle. The first is the end-of-gap timeout of an open packet, and the second is a byte that arrives exactly one cycle too late. The bench provokes this by sending a packet's second byte MAX_GAP+1 cycles after the escape byte, and expects exactly one resend pulse and no command strobe. The other overlap is a command strobe from a finished packet coinciding with the escape byte of the next packet. Back-to-back packets one cycle apart must both decode, and each must raise its own strobe.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
  localparam logic [7:0] ESC      = 8'h1B;
  localparam logic [7:0] OP_INIT  = 8'hA0;
  localparam logic [7:0] OP_DONE  = 8'hA1;
  localparam logic [7:0] OP_BEAT  = 8'hA2;
  localparam logic [7:0] OP_IDENT = 8'hF2;
  localparam logic [7:0] OP_MODE  = 8'hA7;
  localparam logic [7:0] OP_DATA  = 8'hA8;
  localparam logic [7:0] OP_WAKE  = 8'hA9;

  localparam int WAKE_BYTES = 15;
  localparam int WAKE_W     = WAKE_BYTES * 8;
  localparam int POS_W      = 5;

  typedef enum logic {S_IDLE, S_OPEN} frame_st_t;

  function automatic logic [7:0] lrc_fold(input logic [7:0] x);
    return x[7] ? (x ^ 8'hC0) : x;
  endfunction

  // total packet length for a code, 0 when the code is not known
  function automatic logic [POS_W-1:0] pkt_len(input logic [7:0] op);
    case (op)
      OP_INIT, OP_DONE, OP_BEAT, OP_IDENT: return POS_W'(3);
      OP_MODE, OP_DATA:                    return POS_W'(5);
      OP_WAKE:                             return POS_W'(WAKE_BYTES + 3);
      default:                             return '0;
    endcase
  endfunction
endpackage

// File: rtl/hcd_gap_timer.sv
module hcd_gap_timer #(
  parameter int MIN_GAP = 400,
  parameter int MAX_GAP = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic too_early,
  output logic too_late
);
  localparam int CW = $clog2(MAX_GAP + 2);
  localparam logic [CW-1:0] SAT = CW'(MAX_GAP + 1);

  logic [CW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gap_q <= SAT;
    else if (restart)   gap_q <= CW'(1);
    else if (gap_q != SAT) gap_q <= gap_q + CW'(1);
  end

  assign too_early = (gap_q < CW'(MIN_GAP));
  assign too_late  = (gap_q == SAT);

  p_gap_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= SAT);
endmodule

// File: rtl/hcd_framer.sv
module hcd_framer
  import hcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              too_early,
  input  logic              too_late,
  output logic              restart,
  output logic              frame_valid,
  output logic [7:0]        frame_op,
  output logic [WAKE_W-1:0] frame_pl,
  output logic              abort
);
  frame_st_t        st_q;
  logic [POS_W-1:0] pos_q, len_q;
  logic [7:0]       acc_q;
  logic [7:0]       pl_q [WAKE_BYTES];

  assign restart = byte_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      pos_q       <= '0;
      len_q       <= '0;
      acc_q       <= '0;
      frame_op    <= '0;
      frame_valid <= 1'b0;
      abort       <= 1'b0;
      for (int i = 0; i < WAKE_BYTES; i++) pl_q[i] <= '0;
    end else begin
      frame_valid <= 1'b0;
      abort       <= 1'b0;
      case (st_q)
        S_IDLE: if (byte_valid && byte_data == ESC) begin
          st_q  <= S_OPEN;
          pos_q <= POS_W'(1);
          acc_q <= ESC;
        end
        default: begin
          if ((byte_valid && too_early) || too_late) begin
            abort <= 1'b1;
            st_q  <= S_IDLE;
          end else if (byte_valid) begin
            if (pos_q == POS_W'(1)) begin
              if (pkt_len(byte_data) == '0) begin
                abort <= 1'b1;
                st_q  <= S_IDLE;
              end else begin
                frame_op <= byte_data;
                len_q    <= pkt_len(byte_data);
                acc_q    <= acc_q ^ byte_data;
                pos_q    <= POS_W'(2);
              end
            end else if (pos_q == len_q - POS_W'(1)) begin
              st_q <= S_IDLE;
              if (lrc_fold(acc_q) == byte_data) frame_valid <= 1'b1;
              else                              abort       <= 1'b1;
            end else begin
              pl_q[4'(pos_q - POS_W'(2))] <= byte_data;
              acc_q <= acc_q ^ byte_data;
              pos_q <= pos_q + POS_W'(1);
            end
          end
        end
      endcase
    end
  end

  for (genvar g = 0; g < WAKE_BYTES; g++) begin : g_pl
    assign frame_pl[g*8 +: 8] = pl_q[g];
  end

  p_frame_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);
  p_frame_xor_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_valid && abort));
endmodule

// File: rtl/hcd_exec.sv
module hcd_exec
  import hcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_valid,
  input  logic [7:0]        frame_op,
  input  logic [WAKE_W-1:0] frame_pl,
  input  logic              abort,
  output logic              init_p,
  output logic              init_done_p,
  output logic              heartbeat_p,
  output logic              ident_p,
  output logic              mode_query_p,
  output logic              data_query_p,
  output logic              wake_load_p,
  output logic [WAKE_W-1:0] wake_mask,
  output logic              resend_p,
  output logic [2:0]        gio_mode,
  output logic              gio_out
);
  logic [7:0] val;
  assign val = frame_pl[15:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {init_p, init_done_p, heartbeat_p, ident_p} <= '0;
      {mode_query_p, data_query_p, wake_load_p, resend_p} <= '0;
      wake_mask <= '0;
      gio_mode  <= 3'd0;
      gio_out   <= 1'b0;
    end else begin
      {init_p, init_done_p, heartbeat_p, ident_p} <= '0;
      {mode_query_p, data_query_p, wake_load_p} <= '0;
      resend_p <= abort;
      if (frame_valid) begin
        case (frame_op)
          OP_INIT: begin
            init_p   <= 1'b1;
            gio_mode <= 3'd0;
            gio_out  <= 1'b0;
          end
          OP_DONE:  init_done_p <= 1'b1;
          OP_BEAT:  heartbeat_p <= 1'b1;
          OP_IDENT: ident_p     <= 1'b1;
          OP_MODE: begin
            if (val < 8'd4) begin
              gio_mode <= val[2:0];
              if (val == 8'd1) gio_out <= 1'b0;
            end else if (val == 8'd4) mode_query_p <= 1'b1;
            else                      resend_p     <= 1'b1;
          end
          OP_DATA: begin
            if (val < 8'd2) begin
              if (gio_mode == 3'd1) gio_out <= val[0];
            end else if (val == 8'd2) data_query_p <= 1'b1;
            else                      resend_p     <= 1'b1;
          end
          OP_WAKE: begin
            wake_load_p <= 1'b1;
            wake_mask   <= frame_pl;
          end
          default: resend_p <= 1'b1;
        endcase
      end
    end
  end

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({init_p, init_done_p, heartbeat_p, ident_p,
              mode_query_p, data_query_p, wake_load_p, resend_p}));
  p_out_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gio_out != $past(gio_out)) |-> $past(frame_valid));
  p_mode_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gio_mode <= 3'd3);
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_load_p |-> $stable(wake_mask));
endmodule

// File: rtl/host_cmd_decoder.sv
module host_cmd_decoder
  import hcd_pkg::*;
#(
  parameter int MIN_GAP = 400,
  parameter int MAX_GAP = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              init_p,
  output logic              init_done_p,
  output logic              heartbeat_p,
  output logic              ident_p,
  output logic              mode_query_p,
  output logic              data_query_p,
  output logic              wake_load_p,
  output logic [WAKE_W-1:0] wake_mask,
  output logic              resend_p,
  output logic [2:0]        gio_mode,
  output logic              gio_out
);
  logic              restart, too_early, too_late;
  logic              frame_valid, abort;
  logic [7:0]        frame_op;
  logic [WAKE_W-1:0] frame_pl;

  assign in_ready = 1'b1;

  hcd_gap_timer #(.MIN_GAP(MIN_GAP), .MAX_GAP(MAX_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .too_early(too_early), .too_late(too_late));

  hcd_framer u_framer (
    .clk(clk), .rst_n(rst_n), .byte_valid(in_valid), .byte_data(in_data),
    .too_early(too_early), .too_late(too_late), .restart(restart),
    .frame_valid(frame_valid), .frame_op(frame_op), .frame_pl(frame_pl),
    .abort(abort));

  hcd_exec u_exec (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_op(frame_op),
    .frame_pl(frame_pl), .abort(abort),
    .init_p(init_p), .init_done_p(init_done_p), .heartbeat_p(heartbeat_p),
    .ident_p(ident_p), .mode_query_p(mode_query_p), .data_query_p(data_query_p),
    .wake_load_p(wake_load_p), .wake_mask(wake_mask), .resend_p(resend_p),
    .gio_mode(gio_mode), .gio_out(gio_out));

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
endmodule

// File: tb/host_cmd_decoder_bench.sv
module host_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_G = 4;
  localparam int MAX_G = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic init_p, init_done_p, heartbeat_p, ident_p;
  logic mode_query_p, data_query_p, wake_load_p, resend_p, gio_out;
  logic [119:0] wake_mask;
  logic [2:0] gio_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_cmd_decoder #(.MIN_GAP(MIN_G), .MAX_GAP(MAX_G)) u_host_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .init_p(init_p), .init_done_p(init_done_p),
    .heartbeat_p(heartbeat_p), .ident_p(ident_p), .mode_query_p(mode_query_p),
    .data_query_p(data_query_p), .wake_load_p(wake_load_p),
    .wake_mask(wake_mask), .resend_p(resend_p), .gio_mode(gio_mode),
    .gio_out(gio_out));

  int nchk = 0, nerr = 0;
  int cnt [8];
  int base [8];
  logic [7:0] pkt [18];
  int plen;
  logic [2:0] m_mode = 3'd0;
  logic m_out = 1'b0;
  logic [119:0] m_mask = '0;

  // 0 init,1 done,2 heartbeat,3 ident,4 mode query,5 data query,6 wake,7 resend
  always @(negedge clk) if (rst_n) begin
    if (init_p)       cnt[0]++;
    if (init_done_p)  cnt[1]++;
    if (heartbeat_p)  cnt[2]++;
    if (ident_p)      cnt[3]++;
    if (mode_query_p) cnt[4]++;
    if (data_query_p) cnt[5]++;
    if (wake_load_p)  cnt[6]++;
    if (resend_p)     cnt[7]++;
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] calc_lrc(input int n);
    logic [7:0] x = 8'h00;
    for (int i = 0; i < n; i++) x ^= pkt[i];
    if (x[7]) x ^= 8'hC0;
    return x;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic gap_then(input int g, input logic [7:0] b);
    repeat (g - 1) @(negedge clk);
    send_byte(b);
  endtask

  task automatic build(input logic [7:0] op, input logic [7:0] a, input logic [7:0] v);
    pkt[0] = 8'h1B; pkt[1] = op;
    if (op == 8'hA7 || op == 8'hA8) begin
      pkt[2] = a; pkt[3] = v; plen = 5;
    end else if (op == 8'hA9) begin
      for (int i = 0; i < 15; i++) pkt[2+i] = 8'($urandom);
      plen = 18;
    end else plen = 3;
    pkt[plen-1] = calc_lrc(plen - 1);
  endtask

  task automatic send_pkt(input int g);
    send_byte(pkt[0]);
    for (int i = 1; i < plen; i++) gap_then(g, pkt[i]);
  endtask

  task automatic snap();
    for (int i = 0; i < 8; i++) base[i] = cnt[i];
  endtask

  task automatic expect_delta(input string req, input int idx);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++)
      chk($sformatf("%s strobe%0d", req, i), 128'(cnt[i] - base[i]), 128'(i == idx ? 1 : 0));
  endtask

  task automatic chk_regs(input string req);
    chk({req, " mode"}, 128'(gio_mode), 128'(m_mode));
    chk({req, " out"}, 128'(gio_out), 128'(m_out));
  endtask

  // send a built packet and predict the outcome from the requirements
  task automatic run_model(input string req, input int g, input bit corrupt);
    int idx;
    logic [7:0] v;
    if (corrupt) pkt[plen-1] ^= 8'(1 << ($urandom % 8));
    v = pkt[3];
    idx = -1;
    if (corrupt) idx = 7;
    else case (pkt[1])
      8'hA0: begin idx = 0; m_mode = 0; m_out = 0; end
      8'hA1: idx = 1;
      8'hA2: idx = 2;
      8'hF2: idx = 3;
      8'hA7: if (v < 4) begin m_mode = v[2:0]; if (v == 1) m_out = 0; end
             else if (v == 4) idx = 4; else idx = 7;
      8'hA8: if (v < 2) begin if (m_mode == 1) m_out = v[0]; end
             else if (v == 2) idx = 5; else idx = 7;
      8'hA9: begin idx = 6; for (int i = 0; i < 15; i++) m_mask[i*8 +: 8] = pkt[2+i]; end
      default: idx = 7;
    endcase
    snap();
    send_pkt(g);
    expect_delta(req, idx);
    chk_regs(req);
    if (idx == 6) chk({req, " mask"}, 128'(wake_mask), 128'(m_mask));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: reset state ; R10: ready always high
    chk("R7 reset mode", 128'(gio_mode), 0);
    chk("R7 reset out", 128'(gio_out), 0);
    chk("R10 ready", 128'(in_ready), 1);

    // R10: exact latency of a strobe
    build(8'hA2, 0, 0); snap(); send_pkt(MIN_G);
    chk("R10 no early strobe", 128'(heartbeat_p), 0);
    @(negedge clk);
    chk("R10 heartbeat at 2nd edge", 128'(heartbeat_p), 1);
    @(negedge clk);
    chk("R10 single cycle", 128'(heartbeat_p), 0);

    // R2: literal check byte 7Bh for 1B A0
    pkt[0] = 8'h1B; pkt[1] = 8'hA0; pkt[2] = 8'h7B; plen = 3;
    snap(); send_pkt(MIN_G); expect_delta("R2 literal 7B", 0);
    build(8'hA1, 0, 0); run_model("R3 init done", MIN_G, 0);
    build(8'hF2, 0, 0); run_model("R3 ident", MAX_G, 0);
    build(8'hA2, 0, 0); run_model("R2 bad lrc", MIN_G, 1);

    // R1: stray idle bytes ignored
    snap();
    send_byte(8'h55); gap_then(MIN_G, 8'hA2); gap_then(MIN_G, 8'h79);
    expect_delta("R1 idle garbage", -1);
    chk_regs("R1 idle garbage");

    // R3: unknown code
    pkt[0] = 8'h1B; pkt[1] = 8'hB3; pkt[2] = 8'h68; plen = 3;
    snap(); send_pkt(MIN_G); expect_delta("R3 unknown code", 7);

    // R4/R5 directed
    build(8'hA7, 0, 1); run_model("R4 mode output", MIN_G, 0);
    build(8'hA8, 0, 1); run_model("R5 data high", MIN_G, 0);
    build(8'hA7, 0, 2); run_model("R4 mode switch keeps out", MIN_G, 0);
    build(8'hA8, 0, 0); run_model("R5 write ignored off output", MIN_G, 0);
    build(8'hA7, 0, 1); run_model("R4 output clears data", MIN_G, 0);
    build(8'hA7, 0, 4); run_model("R4 mode query", MIN_G, 0);
    build(8'hA7, 0, 5); run_model("R4 mode above 4", MIN_G, 0);
    build(8'hA8, 0, 2); run_model("R5 data query", MIN_G, 0);
    build(8'hA8, 0, 3); run_model("R5 data above 2", MIN_G, 0);
    build(8'hA8, 0, 1); run_model("R5 data high again", MIN_G, 0);
    build(8'hA9, 0, 0); run_model("R6 wake load", MIN_G, 0);
    build(8'hA0, 0, 0); run_model("R7 init resets pin", MIN_G, 0);

    // R8: byte too soon
    build(8'hA2, 0, 0); snap();
    send_byte(pkt[0]); gap_then(MIN_G - 1, pkt[1]); gap_then(MIN_G, pkt[2]);
    expect_delta("R8 early byte", 7);

    // R9: timeout with no byte
    snap();
    send_byte(8'h1B); gap_then(MIN_G, 8'hA2);
    repeat (MAX_G + 4) @(negedge clk);
    send_byte(8'h79);
    expect_delta("R9 timeout", 7);

    // R9: late byte on the timeout cycle gives one resend
    snap();
    send_byte(8'h1B); gap_then(MAX_G + 1, 8'hA2); gap_then(MIN_G, 8'h79);
    expect_delta("R9 late byte", 7);

    // R9: boundary gaps accepted
    build(8'hA1, 0, 0); run_model("R9 gap at max", MAX_G, 0);
    build(8'hA1, 0, 0); run_model("R9 gap at min", MIN_G, 0);

    // R10: back to back packets, next escape right after previous check byte
    build(8'hA2, 0, 0); snap();
    send_pkt(MIN_G);
    build(8'hF2, 0, 0);
    send_pkt(MIN_G);
    repeat (3) @(negedge clk);
    chk("R10 back to back first", 128'(cnt[2] - base[2]), 1);
    chk("R10 back to back second", 128'(cnt[3] - base[3]), 1);
    chk("R10 back to back no resend", 128'(cnt[7] - base[7]), 0);

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [7:0] op;
      case ($urandom % 7)
        0: op = 8'hA0; 1: op = 8'hA1; 2: op = 8'hA2; 3: op = 8'hF2;
        4: op = 8'hA7; 5: op = 8'hA8; default: op = 8'hA9;
      endcase
      build(op, 8'($urandom), (op == 8'hA7) ? 8'($urandom % 6) : 8'($urandom % 4));
      run_model("R3 random", MIN_G + int'($urandom % (MAX_G - MIN_G + 1)), ($urandom % 4) == 0);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule